// File: doc/BRIEF.md
# Bank-Group-Aware DRAM Command Timing Guard

This block watches the command slot of a DDR4-style memory channel and decides, in the same cycle, whether the command being presented may legally go out. A command is an activate (ACT), a column access (CAS, read or write) or a precharge (PRE). Each command names one bank of a rank. The block keeps, for every bank, whether a row is open and how long ago that bank was last activated or precharged. It also keeps rank-wide and per-bank-group spacing state for activates and column accesses, and a small ring that limits how many activates fall inside a rolling window.

A scheduler presents a candidate on `cmd_valid`/`cmd_kind`/`cmd_bank` and reads back the grant that matches the command kind. When it actually sends the command it raises `cmd_fire`. Internal state moves only on such cycles. Every interval is a parameter counted in clock cycles. With a bank-group count of zero, the group-dependent long spacings drop out and only the short values apply.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset every bank is closed and no interval is pending. An ACT to any bank is granted at once, and a CAS or PRE to any bank is not granted.
- R2: `cmd_kind` is encoded 2'b01 = ACT, 2'b10 = CAS, 2'b11 = PRE, 2'b00 = no command. At most one grant is high, and it is the grant for the presented kind. No grant is high while `cmd_valid` is low. With 4 groups of 4 banks, the bank group is `cmd_bank[3:2]`.
- R3: An ACT is not granted until at least T_RRD_S (4) cycles after the last issued ACT to any bank.
- R4: An ACT is not granted until at least T_RRD_L (6) cycles after the last issued ACT to the same bank group.
- R5: At most FAW_ACTS (4) ACTs are issued in any T_FAW (26) cycle span. A further ACT is granted only once the oldest of the last four is at least 26 cycles old.
- R6: A CAS is not granted until at least T_CCD_S (4) cycles after the last issued CAS to any bank.
- R7: A CAS is not granted until at least T_CCD_L (6) cycles after the last issued CAS to the same bank group.
- R8: A CAS to a bank is granted only at least T_RCD (17) cycles after that bank's ACT.
- R9: A PRE to a bank is granted only when the bank is open and at least T_RAS (39) cycles have passed since its ACT.
- R10: An ACT to a bank is granted only at least T_RP (17) cycles after that bank's PRE.
- R11: A CAS to a closed bank or an ACT to an open bank is never granted. If one is fired anyway, `proto_err` is high for exactly the next cycle and no bank or timing state changes.
- R12: With BG_COUNT = 0, ACT and CAS spacing use only T_RRD_S and T_CCD_S, whatever the bank.
- R13: A command that is presented but not fired changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A candidate command is presented |
| cmd_kind | input | 2 | Command kind: 01 ACT, 10 CAS, 11 PRE |
| cmd_bank | input | $clog2(BANKS) | Rank-local bank index, bank group in the upper bits |
| cmd_fire | input | 1 | The presented command is issued this cycle |
| grant_act | output | 1 | Presented ACT meets all rules |
| grant_cas | output | 1 | Presented CAS meets all rules |
| grant_pre | output | 1 | Presented PRE meets all rules |
| proto_err | output | 1 | Previous cycle fired a CAS to a closed bank or an ACT to an open bank |

## Verification
The bench probes each interval one cycle before it expires and again on the cycle it expires. An off-by-one age counter would grant too early or deny one cycle too long. It separates the long same-group spacing from the short spacing by choosing moments when only the long rule can deny: a design that ignored the bank-group field would grant there, while a second instance built flat must grant. It fills the activate window to four entries and probes the fifth ACT at 25 and 26 cycles. It forces an ACT into an open bank and then checks that the later precharge still opens on the original timing. A design that let the illegal command restart the bank's age would deny that precharge, and one that never raised the error flag would be caught on the cycle after.

// File: rtl/dcg_pkg.sv
// Shared types for the DRAM command timing guard.
// Assumes a 2-bit command kind field driven by the scheduler.
package dcg_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_ACT  = 2'b01,
        CMD_CAS  = 2'b10,
        CMD_PRE  = 2'b11
    } dcg_cmd_e;
endpackage

// File: rtl/dcg_age_cnt.sv
// Saturating age counter: done is high once at least LIMIT cycles have passed
// since the last restart. Starts saturated out of reset, so nothing is pending.
// Assumes restart in cycle c makes done true from cycle c+LIMIT on.
module dcg_age_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int unsigned CAP   = (LIMIT == 0) ? 1 : LIMIT;
    localparam int          AW    = $clog2(CAP + 1);
    localparam logic [AW-1:0] CAP_V = AW'(CAP);

    logic [AW-1:0] age_q;

    // Count cycles since the last restart, holding at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= CAP_V;
        else if (restart)
            age_q <= AW'(1);
        else if (age_q != CAP_V)
            age_q <= age_q + AW'(1);
    end

    assign done = (LIMIT == 0) || (age_q >= CAP_V);
endmodule

// File: rtl/dcg_bank_table.sv
// Per-bank row state: open flag plus ages since ACT and since PRE.
// Reports, for the addressed bank, whether it is open and which of the
// row-to-column, row-active and precharge intervals have elapsed.
// Assumes act_ev/pre_ev are already qualified as legal for the bank.
module dcg_bank_table #(
    parameter int unsigned BANKS  = 16,
    parameter int unsigned T_RCD  = 17,
    parameter int unsigned T_RAS  = 39,
    parameter int unsigned T_RP   = 17,
    localparam int         BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic              act_ev,
    input  logic              pre_ev,
    output logic              is_open,
    output logic              rcd_ok,
    output logic              ras_ok,
    output logic              rp_ok
);
    logic [BANKS-1:0] open_q;
    logic [BANKS-1:0] rcd_done;
    logic [BANKS-1:0] ras_done;
    logic [BANKS-1:0] rp_done;

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (bank == BANK_W'(i));

        // Track whether this bank holds an open row.
        always_ff @(posedge clk) begin
            if (!rst_n)
                open_q[i] <= 1'b0;
            else if (hit && act_ev)
                open_q[i] <= 1'b1;
            else if (hit && pre_ev)
                open_q[i] <= 1'b0;
        end

        dcg_age_cnt #(.LIMIT(T_RCD)) u_rcd (
            .clk(clk), .rst_n(rst_n), .restart(hit && act_ev), .done(rcd_done[i]));
        dcg_age_cnt #(.LIMIT(T_RAS)) u_ras (
            .clk(clk), .rst_n(rst_n), .restart(hit && act_ev), .done(ras_done[i]));
        dcg_age_cnt #(.LIMIT(T_RP)) u_rp (
            .clk(clk), .rst_n(rst_n), .restart(hit && pre_ev), .done(rp_done[i]));
    end

    assign is_open = open_q[bank];
    assign rcd_ok  = rcd_done[bank];
    assign ras_ok  = ras_done[bank];
    assign rp_ok   = rp_done[bank];
endmodule

// File: rtl/dcg_spacing.sv
// Command-to-command spacing for one command class (ACT or CAS).
// A rank-wide short interval applies to every pair of commands, and a long
// interval applies between commands to the same group. In flat mode the
// caller passes one group and T_LONG equal to T_SHORT.
module dcg_spacing #(
    parameter int unsigned GROUPS  = 4,
    parameter int unsigned T_SHORT = 4,
    parameter int unsigned T_LONG  = 6,
    localparam int         GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] grp,
    input  logic             ev,
    output logic             ok
);
    logic             short_ok;
    logic [GROUPS-1:0] grp_ok;

    dcg_age_cnt #(.LIMIT(T_SHORT)) u_any (
        .clk(clk), .rst_n(rst_n), .restart(ev), .done(short_ok));

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        dcg_age_cnt #(.LIMIT(T_LONG)) u_same (
            .clk(clk), .rst_n(rst_n), .restart(ev && (grp == GRP_W'(g))), .done(grp_ok[g]));
    end

    assign ok = short_ok && grp_ok[grp];
endmodule

// File: rtl/dcg_act_window.sv
// Rolling activate window: a ring of DEPTH slots, each aging from the ACT it
// recorded. The pointer always names the oldest slot, which must be at least
// T_WIN cycles old before another ACT is allowed. T_WIN of 0 disables it.
module dcg_act_window #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned T_WIN = 26,
    localparam int         PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    output logic ok
);
    if (T_WIN == 0) begin : g_off
        assign ok = 1'b1;
    end else begin : g_on
        logic [PW-1:0]    ptr_q;
        logic [DEPTH-1:0] slot_ok;

        // Advance to the next-oldest slot after recording an ACT.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (ev)
                ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
        end

        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            dcg_age_cnt #(.LIMIT(T_WIN)) u_slot (
                .clk(clk), .rst_n(rst_n), .restart(ev && (ptr_q == PW'(s))), .done(slot_ok[s]));
        end

        assign ok = slot_ok[ptr_q];
    end
endmodule

// File: rtl/dram_cmd_guard.sv
// Bank-group-aware DRAM command timing guard.
// Combinationally grants the presented ACT, CAS or PRE when every timing and
// row-state rule holds. Updates state only on cycles with cmd_fire. A fired
// command that breaks the row state (CAS to closed, ACT to open) changes no
// state and raises proto_err on the next cycle. Assumes banks are numbered
// group-major: bank group = cmd_bank / (BANKS / BG_COUNT).
module dram_cmd_guard #(
    parameter int unsigned BANKS    = 16,
    parameter int unsigned BG_COUNT = 4,
    parameter int unsigned T_CCD_S  = 4,
    parameter int unsigned T_CCD_L  = 6,
    parameter int unsigned T_RRD_S  = 4,
    parameter int unsigned T_RRD_L  = 6,
    parameter int unsigned T_FAW    = 26,
    parameter int unsigned FAW_ACTS = 4,
    parameter int unsigned T_RCD    = 17,
    parameter int unsigned T_RP     = 17,
    parameter int unsigned T_RAS    = 39,
    localparam int         BANK_W   = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_fire,
    output logic              grant_act,
    output logic              grant_cas,
    output logic              grant_pre,
    output logic              proto_err
);
    import dcg_pkg::*;

    localparam int unsigned NG    = (BG_COUNT == 0) ? 1 : BG_COUNT;
    localparam int unsigned BPG   = BANKS / NG;
    localparam int          GRP_W = (NG > 1) ? $clog2(NG) : 1;
    localparam int unsigned TCL   = (BG_COUNT == 0) ? T_CCD_S : T_CCD_L;
    localparam int unsigned TRL   = (BG_COUNT == 0) ? T_RRD_S : T_RRD_L;

    logic [GRP_W-1:0] grp;
    logic is_act, is_cas, is_pre, fire;
    logic is_open, rcd_ok, ras_ok, rp_ok;
    logic act_space_ok, cas_space_ok, win_ok;
    logic act_ev, cas_ev, pre_ev, err_d, err_q;

    assign grp    = GRP_W'(cmd_bank / BPG);
    assign is_act = cmd_valid && (cmd_kind == CMD_ACT);
    assign is_cas = cmd_valid && (cmd_kind == CMD_CAS);
    assign is_pre = cmd_valid && (cmd_kind == CMD_PRE);
    assign fire   = cmd_valid && cmd_fire;

    // Only commands legal for the row state move any state.
    assign act_ev = fire && is_act && !is_open;
    assign cas_ev = fire && is_cas && is_open;
    assign pre_ev = fire && is_pre && is_open;
    assign err_d  = fire && ((is_act && is_open) || (is_cas && !is_open));

    dcg_bank_table #(.BANKS(BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) u_banks (
        .clk(clk), .rst_n(rst_n), .bank(cmd_bank), .act_ev(act_ev), .pre_ev(pre_ev),
        .is_open(is_open), .rcd_ok(rcd_ok), .ras_ok(ras_ok), .rp_ok(rp_ok));

    dcg_spacing #(.GROUPS(NG), .T_SHORT(T_RRD_S), .T_LONG(TRL)) u_act_sp (
        .clk(clk), .rst_n(rst_n), .grp(grp), .ev(act_ev), .ok(act_space_ok));

    dcg_spacing #(.GROUPS(NG), .T_SHORT(T_CCD_S), .T_LONG(TCL)) u_cas_sp (
        .clk(clk), .rst_n(rst_n), .grp(grp), .ev(cas_ev), .ok(cas_space_ok));

    dcg_act_window #(.DEPTH(FAW_ACTS), .T_WIN(T_FAW)) u_win (
        .clk(clk), .rst_n(rst_n), .ev(act_ev), .ok(win_ok));

    // Register the protocol-error pulse for the cycle after a forced command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= err_d;
    end

    assign grant_act = is_act && !is_open && rp_ok && act_space_ok && win_ok;
    assign grant_cas = is_cas && is_open && rcd_ok && cas_space_ok;
    assign grant_pre = is_pre && is_open && ras_ok;
    assign proto_err = err_q;
endmodule

// File: rtl/dcg_checker.sv
// Property checker for dram_cmd_guard, attached by bind. Keeps its own
// cycle gaps since the last granted-and-fired ACT and CAS.
module dcg_checker #(
    parameter int unsigned T_RRD_S = 4,
    parameter int unsigned T_CCD_S = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_kind,
    input logic       cmd_fire,
    input logic       grant_act,
    input logic       grant_cas,
    input logic       grant_pre,
    input logic       proto_err
);
    import dcg_pkg::*;

    logic [7:0] act_gap, cas_gap;

    // Cycles since the last granted ACT that was fired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_gap <= 8'hFF;
        else if (cmd_valid && cmd_fire && grant_act)
            act_gap <= 8'd1;
        else if (act_gap != 8'hFF)
            act_gap <= act_gap + 8'd1;
    end

    // Cycles since the last granted CAS that was fired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cas_gap <= 8'hFF;
        else if (cmd_valid && cmd_fire && grant_cas)
            cas_gap <= 8'd1;
        else if (cas_gap != 8'hFF)
            cas_gap <= cas_gap + 8'd1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_act, grant_cas, grant_pre})); // R2
    AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> !(grant_act || grant_cas || grant_pre)); // R2
    AST_GRANT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        grant_act |-> (cmd_kind == CMD_ACT)); // R2
    AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        grant_act |-> (32'(act_gap) >= T_RRD_S)); // R3
    AST_CAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        grant_cas |-> (32'(cas_gap) >= T_CCD_S)); // R6
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(cmd_valid && cmd_fire && !grant_act && !grant_cas
                            && (cmd_kind == CMD_ACT || cmd_kind == CMD_CAS))); // R11
endmodule

bind dram_cmd_guard dcg_checker #(.T_RRD_S(T_RRD_S), .T_CCD_S(T_CCD_S)) u_dcg_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_fire(cmd_fire), .grant_act(grant_act), .grant_cas(grant_cas),
    .grant_pre(grant_pre), .proto_err(proto_err));

// File: tb/dram_cmd_guard_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver presents one command per cycle and queues the
// expected grants and error flag; the monitor pops and compares.
module dram_cmd_guard_test;
    localparam logic [1:0] K_NONE = 2'b00;
    localparam logic [1:0] K_ACT  = 2'b01;
    localparam logic [1:0] K_CAS  = 2'b10;
    localparam logic [1:0] K_PRE  = 2'b11;

    typedef struct {
        logic [3:0] exp;
        logic       chk_flat;
        logic [2:0] exp_flat;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = K_NONE;
    logic [3:0] cmd_bank = '0;
    logic       cmd_fire = 1'b0;
    logic       grant_act, grant_cas, grant_pre, proto_err;
    logic       f_act, f_cas, f_pre, f_err;

    int    n_tests = 0;
    int    n_fail  = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    dram_cmd_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_fire(cmd_fire), .grant_act(grant_act),
        .grant_cas(grant_cas), .grant_pre(grant_pre), .proto_err(proto_err));

    dram_cmd_guard #(.BG_COUNT(0)) uut_flat (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_fire(cmd_fire), .grant_act(f_act),
        .grant_cas(f_cas), .grant_pre(f_pre), .proto_err(f_err));

    // Monitor: compare each queued expectation with the settled outputs.
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            n_tests++;
            if ({grant_act, grant_cas, grant_pre, proto_err} !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual act/cas/pre/err=%b expected=%b", it.tag,
                         {grant_act, grant_cas, grant_pre, proto_err}, it.exp);
            end
            if (it.chk_flat) begin
                n_tests++;
                if ({f_act, f_cas, f_pre} !== it.exp_flat) begin
                    n_fail++;
                    $display("FAIL %s flat: actual act/cas/pre=%b expected=%b", it.tag,
                             {f_act, f_cas, f_pre}, it.exp_flat);
                end
            end
        end
    end

    // Driver: present a command for one cycle and queue what must be seen.
    task automatic step(input logic [1:0] k, input int b, input logic f,
                        input logic [2:0] g, input logic e, input string tag,
                        input logic cf = 1'b0, input logic [2:0] fg = 3'b000);
        item_t it;
        @(negedge clk);
        cmd_valid = (k != K_NONE);
        cmd_kind  = k;
        cmd_bank  = 4'(b);
        cmd_fire  = f;
        #1;
        it.exp = {g, e};
        it.chk_flat = cf;
        it.exp_flat = fg;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cmd_kind  = K_NONE;
            cmd_fire  = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_kind  = K_NONE;
        cmd_fire  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Phase A: activate spacing and the rolling window.
        do_reset();
        step(K_ACT, 0, 1, 3'b100, 0, "R1 act after reset", 1, 3'b100);         // c0
        step(K_ACT, 4, 0, 3'b000, 0, "R3 act other group gap1", 1, 3'b000);    // c1
        idle(2);                                                               // c2-3
        step(K_ACT, 1, 0, 3'b000, 0, "R4 act same group gap4", 1, 3'b100);     // c4, R12 flat
        step(K_ACT, 1, 0, 3'b000, 0, "R4 act same group gap5");                // c5
        step(K_ACT, 1, 1, 3'b100, 0, "R4 act same group gap6");                // c6
        step(K_ACT, 4, 0, 3'b000, 0, "R3 act gap1");                           // c7
        idle(1);                                                               // c8
        step(K_ACT, 4, 0, 3'b000, 0, "R3 act gap3");                           // c9
        step(K_ACT, 4, 1, 3'b100, 0, "R3 R13 act gap4");                       // c10
        idle(3);                                                               // c11-13
        step(K_ACT, 8, 1, 3'b100, 0, "R5 fourth act");                         // c14
        idle(3);                                                               // c15-17
        step(K_ACT, 12, 0, 3'b000, 0, "R5 fifth act window age18", 1, 3'b000); // c18
        idle(6);                                                               // c19-24
        step(K_ACT, 12, 0, 3'b000, 0, "R5 fifth act window age25");            // c25
        step(K_ACT, 12, 1, 3'b100, 0, "R5 fifth act window age26");            // c26
        step(K_CAS, 0, 0, 3'b010, 0, "R2 only cas grant for cas kind");        // c27
        step(K_ACT, 0, 0, 3'b000, 0, "R11 act to open bank");                  // c28
        step(K_NONE, 0, 0, 3'b000, 0, "R2 no grant without valid");            // c29

        // Phase B: column access spacing and row-to-column delay.
        do_reset();
        step(K_ACT, 0, 1, 3'b100, 0, "R8 open b0");                            // c0
        idle(3);
        step(K_ACT, 4, 1, 3'b100, 0, "R8 open b4");                            // c4
        idle(3);
        step(K_ACT, 1, 1, 3'b100, 0, "R8 open b1");                            // c8
        idle(7);                                                               // c9-15
        step(K_CAS, 0, 0, 3'b000, 0, "R8 cas at rcd-1");                       // c16
        step(K_CAS, 0, 0, 3'b010, 0, "R8 R13 cas at rcd");                     // c17
        step(K_CAS, 0, 1, 3'b010, 0, "R8 cas b0 issue");                       // c18
        idle(2);                                                               // c19-20
        step(K_CAS, 4, 0, 3'b000, 0, "R6 cas other group gap3");               // c21
        step(K_CAS, 4, 1, 3'b010, 0, "R6 cas other group gap4");               // c22
        idle(3);                                                               // c23-25
        step(K_CAS, 1, 1, 3'b010, 0, "R6 cas b1 group0 gap8");                 // c26
        idle(3);                                                               // c27-29
        step(K_CAS, 0, 0, 3'b000, 0, "R7 cas same group gap4", 1, 3'b010);     // c30, R12 flat
        step(K_CAS, 0, 0, 3'b000, 0, "R7 cas same group gap5");                // c31
        step(K_CAS, 0, 1, 3'b010, 0, "R7 cas same group gap6");                // c32

        // Phase C: row active, precharge, protocol errors.
        do_reset();
        step(K_CAS, 2, 0, 3'b000, 0, "R1 cas after reset");                    // c0
        step(K_PRE, 2, 0, 3'b000, 0, "R1 pre after reset");                    // c1
        step(K_ACT, 2, 1, 3'b100, 0, "R10 open b2");                           // c2
        step(K_ACT, 2, 1, 3'b000, 0, "R11 forced act to open bank");           // c3
        step(K_PRE, 2, 0, 3'b000, 1, "R11 error flag after forced act");       // c4
        step(K_PRE, 2, 0, 3'b000, 0, "R11 error flag lasts one cycle");        // c5
        idle(34);                                                              // c6-39
        step(K_PRE, 2, 0, 3'b000, 0, "R9 pre at ras-1");                       // c40
        step(K_PRE, 2, 1, 3'b001, 0, "R9 R11 pre at ras, forced act ignored"); // c41
        step(K_CAS, 2, 1, 3'b000, 0, "R11 forced cas to closed bank");         // c42
        step(K_ACT, 2, 0, 3'b000, 1, "R10 R11 act gap2 with error");           // c43
        idle(13);                                                              // c44-56
        step(K_ACT, 2, 0, 3'b000, 0, "R10 act at rp-1");                       // c57
        step(K_ACT, 2, 1, 3'b100, 0, "R10 act at rp");                         // c58
        step(K_CAS, 2, 0, 3'b000, 0, "R8 cas right after act");                // c59

        idle(2);
        wait (sb_q.size() == 0);
        #1;
        finish_run();
    end
endmodule